// File: doc/BRIEF.md
# Layered Ternary Lookup Table

This block is a ternary match table held in ordinary flip-flop storage instead of a match-line array. Each entry carries a value and a care mask: key bits under a cleared care bit match either level. The entry store is cut two ways. Horizontally, it is split into layers, and each layer owns a contiguous run of entry addresses. Vertically, the key is split into equal subwords. Every (layer, subword) pair is one sub-table, and each sub-table is a row-addressed bit table. The subword value selects a row, and each bit of that row marks an entry of the layer whose subword accepts that value.

A search presents the key to every layer at once. Each layer reads one row per subword and ANDs the rows into a per-entry match vector. A local priority encoder turns that vector into the lowest matching index, and this result is registered. A global stage then picks the lowest-numbered layer that reports a hit. It joins that layer number with the local index to form the entry address, and registers the result. A result therefore appears two clock edges after the search is sampled.

Entries are written through a mapping port one at a time. A write updates every row of each sub-table in the addressed layer in a single cycle, and a write with the live flag low removes the entry.

Top module: `hpt_lookup`

## Requirements
- R1: After reset, res_vld, res_hit and res_addr are all 0 and no entry is live, so the first search reports a miss.
- R2: A search hits a live entry exactly when the key equals the entry value on every bit whose care bit is 1.
- R3: Key bits at positions whose care bit is 0 never prevent a match, whatever their value.
- R4: When several entries of one layer match, the lowest address among them is reported.
- R5: When entries in different layers match, the lowest-numbered layer wins. The reported address is the layer number times the entries per layer plus the local index, which is the same as the lowest matching address over the whole table.
- R6: When no live entry matches, res_vld is 1, res_hit is 0 and res_addr is 0.
- R7: A key sampled with srch_vld high at a rising edge produces res_vld high two rising edges later. Cycles without srch_vld produce res_vld low.
- R8: A mapping write with map_live low removes that entry, so it no longer matches any key.
- R9: A search sampled on the same edge as a mapping write sees the table as it was before that write.
- R10: Rewriting an address replaces its previous value and care mask completely.
- R11: While res_vld is 0, res_hit and res_addr are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_we | input | 1 | Mapping write strobe |
| map_addr | input | 3 | Entry address to write (upper bit selects the layer) |
| map_value | input | 8 | Entry value |
| map_care | input | 8 | Care mask, 1 = bit compared |
| map_live | input | 1 | 1 installs the entry, 0 removes it |
| srch_vld | input | 1 | Search request |
| srch_key | input | 8 | Search key |
| res_vld | output | 1 | Result valid |
| res_hit | output | 1 | A live entry matched |
| res_addr | output | 3 | Winning entry address, 0 on miss |

## Verification
Each search result is due two rising edges after its key is sampled: one edge for the layer stage and one for the global stage. A mapping write takes effect for searches sampled on the next edge or later. The bench drives inputs on falling edges and keeps a two-deep queue of expected results. Each expected result is computed from a flat behavioural table that scans all addresses, lowest address first, and the table is updated only after the search of the same cycle has been evaluated. On every falling edge the outputs are compared with the entry that has aged two cycles in the queue, so idle cycles are checked as well as searches.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int unsigned HPT_KEY_W   = 8;
  localparam int unsigned HPT_SUB_W   = 4;
  localparam int unsigned HPT_ENTRIES = 8;
  localparam int unsigned HPT_LAYERS  = 2;
endpackage

// File: rtl/hpt_prio_enc.sv
module hpt_prio_enc #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [AW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = AW'(i);
      end
    end
  end
endmodule

// File: rtl/hpt_subtable.sv
module hpt_subtable #(
  parameter int unsigned SUB_W = 4,
  parameter int unsigned ENT   = 4,
  parameter int unsigned EAW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [EAW-1:0]   wr_idx,
  input  logic [SUB_W-1:0] wr_pat,
  input  logic [SUB_W-1:0] wr_care,
  input  logic             wr_live,
  input  logic [SUB_W-1:0] rd_val,
  output logic [ENT-1:0]   rd_row
);
  localparam int unsigned ROWS = 1 << SUB_W;

  logic [ENT-1:0] row_q [ROWS];
  logic [ENT-1:0] row_d [ROWS];
  logic [ENT-1:0] col_any;

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      row_d[r] = row_q[r];
      if (wr_en)
        row_d[r][wr_idx] = wr_live && (((SUB_W'(r) ^ wr_pat) & wr_care) == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) row_q[r] <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < ROWS; r++) row_q[r] <= row_d[r];
    end
  end

  assign rd_row = row_q[rd_val];

  always_comb begin
    col_any = '0;
    for (int r = 0; r < ROWS; r++) col_any = col_any | row_q[r];
  end

  AST_REMOVED_COLUMN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_live) |=> !col_any[$past(wr_idx)]); // R8

  AST_STORED_ROW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_live) |=> row_q[$past(wr_pat & wr_care)][$past(wr_idx)]); // R2
endmodule

// File: rtl/hpt_layer.sv
module hpt_layer #(
  parameter int unsigned KEY_W = 8,
  parameter int unsigned SUB_W = 4,
  parameter int unsigned ENT   = 4,
  parameter int unsigned EAW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             map_en,
  input  logic [EAW-1:0]   map_idx,
  input  logic [KEY_W-1:0] map_pat,
  input  logic [KEY_W-1:0] map_care,
  input  logic             map_live,
  input  logic             key_vld,
  input  logic [KEY_W-1:0] key,
  output logic             loc_vld,
  output logic             loc_hit,
  output logic [EAW-1:0]   loc_idx
);
  localparam int unsigned PARTS = KEY_W / SUB_W;

  logic [ENT-1:0] part_row [PARTS];
  logic [ENT-1:0] match_vec;
  logic           pe_any;
  logic [EAW-1:0] pe_idx;
  logic           vld_d, hit_d;
  logic [EAW-1:0] idx_d;
  logic [ENT-1:0] low_mask;

  for (genvar p = 0; p < PARTS; p++) begin : g_part
    hpt_subtable #(.SUB_W(SUB_W), .ENT(ENT), .EAW(EAW)) u_sub (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (map_en),
      .wr_idx  (map_idx),
      .wr_pat  (map_pat[p*SUB_W +: SUB_W]),
      .wr_care (map_care[p*SUB_W +: SUB_W]),
      .wr_live (map_live),
      .rd_val  (key[p*SUB_W +: SUB_W]),
      .rd_row  (part_row[p])
    );
  end

  always_comb begin
    match_vec = '1;
    for (int p = 0; p < PARTS; p++) match_vec = match_vec & part_row[p];
  end

  hpt_prio_enc #(.N(ENT), .AW(EAW)) u_local_pe (
    .req (match_vec),
    .any (pe_any),
    .idx (pe_idx)
  );

  always_comb begin
    vld_d = key_vld;
    hit_d = key_vld && pe_any;
    idx_d = hit_d ? pe_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_vld <= 1'b0;
      loc_hit <= 1'b0;
      loc_idx <= '0;
    end else begin
      loc_vld <= vld_d;
      loc_hit <= hit_d;
      loc_idx <= idx_d;
    end
  end

  assign low_mask = (ENT'(1) << loc_idx) - ENT'(1);

  AST_LOCAL_HIT_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
    loc_hit |-> ((($past(match_vec) >> loc_idx) & ENT'(1)) != '0)); // R2

  AST_LOCAL_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    loc_hit |-> (($past(match_vec) & low_mask) == '0)); // R4
endmodule

// File: rtl/hpt_lookup.sv
module hpt_lookup #(
  parameter int unsigned KEY_W   = hpt_pkg::HPT_KEY_W,
  parameter int unsigned SUB_W   = hpt_pkg::HPT_SUB_W,
  parameter int unsigned ENTRIES = hpt_pkg::HPT_ENTRIES,
  parameter int unsigned LAYERS  = hpt_pkg::HPT_LAYERS,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             map_we,
  input  logic [AW-1:0]    map_addr,
  input  logic [KEY_W-1:0] map_value,
  input  logic [KEY_W-1:0] map_care,
  input  logic             map_live,
  input  logic             srch_vld,
  input  logic [KEY_W-1:0] srch_key,
  output logic             res_vld,
  output logic             res_hit,
  output logic [AW-1:0]    res_addr
);
  localparam int unsigned LENT = ENTRIES / LAYERS;
  localparam int unsigned LAW  = $clog2(LENT);
  localparam int unsigned LYW  = AW - LAW;

  logic [LAYERS-1:0] lay_vld;
  logic [LAYERS-1:0] lay_hit;
  logic [LAW-1:0]    lay_idx [LAYERS];
  logic              g_any;
  logic [LYW-1:0]    g_lay;
  logic              vld_d, hit_d;
  logic [AW-1:0]     addr_d;
  logic [LAYERS-1:0] lower_layers;

  for (genvar g = 0; g < LAYERS; g++) begin : g_layer
    logic sel;
    assign sel = map_we && (map_addr[AW-1:LAW] == LYW'(g));
    hpt_layer #(.KEY_W(KEY_W), .SUB_W(SUB_W), .ENT(LENT), .EAW(LAW)) u_layer (
      .clk      (clk),
      .rst_n    (rst_n),
      .map_en   (sel),
      .map_idx  (map_addr[LAW-1:0]),
      .map_pat  (map_value),
      .map_care (map_care),
      .map_live (map_live),
      .key_vld  (srch_vld),
      .key      (srch_key),
      .loc_vld  (lay_vld[g]),
      .loc_hit  (lay_hit[g]),
      .loc_idx  (lay_idx[g])
    );
  end

  hpt_prio_enc #(.N(LAYERS), .AW(LYW)) u_global_pe (
    .req (lay_hit),
    .any (g_any),
    .idx (g_lay)
  );

  always_comb begin
    vld_d  = lay_vld[0];
    hit_d  = lay_vld[0] && g_any;
    addr_d = hit_d ? {g_lay, lay_idx[g_lay]} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_hit  <= 1'b0;
      res_addr <= '0;
    end else begin
      res_vld  <= vld_d;
      res_hit  <= hit_d;
      res_addr <= addr_d;
    end
  end

  assign lower_layers = (LAYERS'(1) << res_addr[AW-1:LAW]) - LAYERS'(1);

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld == $past(srch_vld, 2)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> (!res_hit && res_addr == '0)); // R11

  AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_hit) |-> (res_addr == '0)); // R6

  AST_LOWEST_LAYER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (($past(lay_hit) & lower_layers) == '0)); // R5
endmodule

// File: tb/tb_hpt_lookup.sv
module tb_hpt_lookup;
  localparam int PERIOD = 10;
  localparam int KW = 8;
  localparam int NE = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic map_we = 1'b0;
  logic [AW-1:0] map_addr = '0;
  logic [KW-1:0] map_value = '0;
  logic [KW-1:0] map_care = '0;
  logic map_live = 1'b0;
  logic srch_vld = 1'b0;
  logic [KW-1:0] srch_key = '0;
  logic res_vld, res_hit;
  logic [AW-1:0] res_addr;

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R1";

  logic [KW-1:0] m_val [NE];
  logic [KW-1:0] m_care [NE];
  logic          m_live [NE];
  logic          e_v [2];
  logic          e_h [2];
  logic [AW-1:0] e_a [2];

  always #(PERIOD/2) clk = ~clk;

  hpt_lookup dut (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_addr(map_addr),
    .map_value(map_value), .map_care(map_care), .map_live(map_live),
    .srch_vld(srch_vld), .srch_key(srch_key),
    .res_vld(res_vld), .res_hit(res_hit), .res_addr(res_addr)
  );

  task automatic compare(input logic v, input logic h, input logic [AW-1:0] a);
    n_chk++;
    if (res_vld !== v || res_hit !== h || res_addr !== a) begin
      n_bad++;
      $display("FAIL %s: got vld=%0d hit=%0d addr=%0d expected vld=%0d hit=%0d addr=%0d",
               tag, res_vld, res_hit, res_addr, v, h, a);
    end
  endtask

  // one cycle: check aged expectation, then drive new inputs and update the model
  task automatic tick(input logic we, input int addr, input logic [KW-1:0] val,
                      input logic [KW-1:0] care, input logic live,
                      input logic sv, input logic [KW-1:0] key);
    logic nh;
    logic [AW-1:0] na;
    @(negedge clk);
    compare(e_v[1], e_h[1], e_a[1]);
    nh = 1'b0;
    na = '0;
    if (sv) begin
      for (int i = NE - 1; i >= 0; i--) begin
        if (m_live[i] && (((key ^ m_val[i]) & m_care[i]) == '0)) begin
          nh = 1'b1;
          na = AW'(i);
        end
      end
    end
    e_v[1] = e_v[0]; e_h[1] = e_h[0]; e_a[1] = e_a[0];
    e_v[0] = sv;     e_h[0] = nh;     e_a[0] = na;
    map_we = we; map_addr = AW'(addr); map_value = val; map_care = care;
    map_live = live; srch_vld = sv; srch_key = key;
    if (we) begin
      m_val[addr] = val; m_care[addr] = care; m_live[addr] = live;
    end
  endtask

  task automatic wr(input int addr, input logic [KW-1:0] val, input logic [KW-1:0] care);
    tick(1'b1, addr, val, care, 1'b1, 1'b0, '0);
  endtask

  task automatic sr(input logic [KW-1:0] key);
    tick(1'b0, 0, '0, '0, 1'b0, 1'b1, key);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 0, '0, '0, 1'b0, 1'b0, '0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got no completion expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_val[i] = '0; m_care[i] = '0; m_live[i] = 1'b0;
    end
    for (int i = 0; i < 2; i++) begin
      e_v[i] = 1'b0; e_h[i] = 1'b0; e_a[i] = '0;
    end
    tag = "R1 reset";
    repeat (3) begin
      @(negedge clk);
      compare(1'b0, 1'b0, '0);
    end
    rst_n = 1'b1;
    idle(2);
    tag = "R1 empty table";
    sr(8'h00); sr(8'hFF); idle(2);

    tag = "R2 exact";
    wr(5, 8'h3C, 8'hFF); wr(1, 8'hA5, 8'hFF);
    sr(8'h3C); sr(8'hA5); sr(8'h3D); sr(8'hA4); idle(2);

    tag = "R3 dont care";
    wr(2, 8'h70, 8'hF0); wr(6, 8'h05, 8'h0F);
    sr(8'h70); sr(8'h7F); sr(8'h7A); sr(8'hE5); sr(8'h35); sr(8'h80); idle(2);

    tag = "R4 layer order";
    wr(3, 8'h11, 8'hFF); wr(0, 8'h10, 8'hF0);
    sr(8'h11); sr(8'h12); idle(2);

    tag = "R5 cross layer";
    wr(7, 8'h99, 8'hFF); wr(4, 8'h90, 8'hF0);
    sr(8'h99); sr(8'h9E);
    wr(2, 8'h09, 8'h0F);
    sr(8'h99); sr(8'h29); idle(2);

    tag = "R6 miss";
    sr(8'hEE); sr(8'h00); idle(2);

    tag = "R8 remove";
    tick(1'b1, 0, 8'h10, 8'hF0, 1'b0, 1'b0, '0);
    sr(8'h11); sr(8'h1F); idle(2);

    tag = "R9 same cycle";
    tick(1'b1, 3, 8'h11, 8'hFF, 1'b0, 1'b1, 8'h11);
    sr(8'h11);
    tick(1'b1, 0, 8'hEE, 8'hFF, 1'b1, 1'b1, 8'hEE);
    sr(8'hEE); idle(2);

    tag = "R10 overwrite";
    wr(5, 8'h42, 8'hFF);
    sr(8'h3C); sr(8'h42); idle(2);

    tag = "R7 latency";
    sr(8'h42); idle(1); sr(8'hEE); idle(3); sr(8'h99); sr(8'h77); sr(8'h42); idle(2);

    tag = "R11 idle";
    idle(4);

    tag = "R5 random vs flat";
    for (int i = 0; i < NE; i++) tick(1'b1, i, '0, '0, 1'b0, 1'b0, '0);
    for (int i = 0; i < NE; i++) wr(i, KW'($urandom), KW'($urandom | $urandom));
    for (int n = 0; n < 300; n++) begin
      int r;
      logic [KW-1:0] k;
      r = $urandom % NE;
      k = m_val[r] ^ (KW'($urandom) & ~m_care[r]);
      if (($urandom % 4) == 0) k = KW'($urandom);
      if (($urandom % 8) == 0)
        tick(1'b1, $urandom % NE, KW'($urandom), KW'($urandom | $urandom),
             1'($urandom), 1'b1, k);
      else
        tick(1'b0, 0, '0, '0, 1'b0, 1'($urandom % 4 != 0), k);
    end
    idle(3);
    summary();
  end
endmodule